// File: doc/BRIEF.md
# Serial Receive Queue with Character Timeout

This block holds the bytes a serial receiver has deserialized until the host collects them through the receive-buffer read port. It has two modes. In queue mode it keeps up to sixteen bytes in arrival order. In single-byte mode, which is the mode after reset, it holds one byte. An incoming byte that finds no room is dropped and raises the overrun flag. A received break line condition enters the queue as a zero byte and raises the break flag. The host sets a fill threshold, and a flag tells it when the queue has reached that threshold.

A character-time tick comes from the baud generator, one pulse per frame time. The block counts these ticks to detect an idle line while data is still waiting. Four character times without a new byte or a read set a timeout flag, so the host can collect a partial batch that is below the threshold.

Writes to the FIFO-control register set the mode and the threshold. They also request flushes of the receive queue and of the companion transmit queue. A flush of the transmit queue is signalled with a one-cycle pulse to that queue.

Top module: `uart_rxq`

## Requirements
- R1: In queue mode (stored control bit 0 = 1) bytes are kept in arrival order up to DEPTH (16). `rbr_data` shows the oldest byte whenever `rx_fill` > 0 and shows 0 when the queue is empty. A cycle with `rbr_rd` high removes the oldest byte.
- R2: A byte arriving in a cycle that starts with no room is discarded and sets `ls_oe`, and the stored bytes stay unchanged. No room means `rx_fill` = DEPTH in queue mode, or `ls_dr` = 1 in single-byte mode. A same-cycle read does not make room. `lsr_rd` clears `ls_oe` unless a new overrun occurs in that same cycle.
- R3: `rx_trig` is high in queue mode when `rx_fill` is at least the threshold set by stored control bits 7:6. The codes map 00 to 1, 01 to 4, 10 to 8 and 11 to 14 bytes.
- R4: When `rx_brk` is high and there is room, the byte 0x00 is stored whatever `rx_byte` holds, and `ls_bi` and `ls_dr` are set. A break that meets a full queue only sets `ls_oe`.
- R5: `ls_dr` is 1 exactly when `rx_fill` > 0. A read that leaves the queue empty clears `ls_dr` and `ls_bi`. `lsr_rd` clears `ls_bi`, but a break stored in the same cycle takes precedence.
- R6: In queue mode the timeout counter restarts in every cycle with an arriving byte, including a discarded one, and in every cycle with a read that leaves data behind. Ticks in the restarting cycle do not count. `rx_tmo` rises at the clock edge that ends the cycle holding the fourth `char_tick` after the restart, provided data is still queued.
- R7: Any cycle with `rbr_rd` high clears `rx_tmo`, even when the queue is empty.
- R8: A control write stores only bits 7:6, 3 and 0 (mask 0xC9), and `fcr_q` shows the stored value.
- R9: A control write with bit 1 set, or one that changes bit 0, flushes the receive queue. It empties the queue, clears `ls_dr`, `ls_bi` and `rx_tmo`, and stops the timer, but leaves `ls_oe` unchanged. A byte or read in that cycle is ignored.
- R10: A control write with bit 2 set, or one that changes bit 0, produces a one-cycle `tx_flush` pulse in the next cycle.
- R11: In single-byte mode the capacity is one byte, `rx_trig` equals `ls_dr`, and `rx_tmo` never sets.
- R12: After reset the stored control value is 0 (single-byte mode), the queue is empty, and every flag and `tx_flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| rx_brk | input | 1 | A break condition was received this cycle |
| rbr_rd | input | 1 | Host read of the receive buffer |
| lsr_rd | input | 1 | Host read of the line status |
| fcr_wr | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write data |
| char_tick | input | 1 | One pulse per character time |
| rbr_data | output | 8 | Oldest queued byte, 0 when empty |
| rx_fill | output | $clog2(DEPTH+1) | Number of queued bytes |
| rx_trig | output | 1 | Threshold reached |
| rx_tmo | output | 1 | Character timeout pending |
| ls_dr | output | 1 | Data ready |
| ls_oe | output | 1 | Overrun error |
| ls_bi | output | 1 | Break received |
| tx_flush | output | 1 | Transmit queue flush pulse |
| fcr_q | output | 8 | Stored control value |

## Verification
The assertions take for granted that the host never writes the control register while expecting a byte or a read in the same cycle to take effect. They also assume that `char_tick` is a single-cycle pulse with no fixed relation to reads. The overrun assertion fires only in cycles with no read and no control write, so the stimulus is free to mix all three. The bench drives a random mix of those events, with rare writes that toggle the mode. A behavioural reference queue stays correct even when a flush, a read and an arrival coincide.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  FCR_KEEP = 8'hC9;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_code_e;

    // control register layout, bit 7 first
    typedef struct packed {
        trig_code_e trig;
        logic [1:0] spare;
        logic       dma_sel;
        logic       tx_clr;
        logic       rx_clr;
        logic       enable;
    } fcr_t;

    typedef struct packed {
        logic dr;
        logic oe;
        logic bi;
    } line_stat_t;

    function automatic int unsigned trig_level(trig_code_e c);
        case (c)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, wnext, rnext;
    logic [CNT_W-1:0] count_q;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wnext = wptr + 1'b1;
            assign rnext = rptr + 1'b1;
        end else begin : g_wrap
            assign wnext = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            assign rnext = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_i && !clr_i)
            mem[wptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wptr    <= '0;
            rptr    <= '0;
            count_q <= '0;
        end else begin
            if (push_i) wptr <= wnext;
            if (pop_i)  rptr <= rnext;
            count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    assign head_o  = mem[rptr];
    assign count_o = count_q;

    // R1
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_W'(DEPTH)) |-> !push_i);

    // R1
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0) |-> !pop_i);

endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
    parameter int CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic stop_i,
    input  logic tick_i,
    output logic fire_o
);
    localparam int TW = (CHARS > 1) ? $clog2(CHARS) : 1;

    logic          armed;
    logic [TW-1:0] ticks;
    logic          last;

    assign last   = (ticks == TW'(CHARS - 1));
    assign fire_o = armed & tick_i & last & ~restart_i & ~stop_i;

    always_ff @(posedge clk) begin
        if (rst || stop_i) begin
            armed <= 1'b0;
            ticks <= '0;
        end else if (restart_i) begin
            armed <= 1'b1;
            ticks <= '0;
        end else if (armed && tick_i) begin
            if (last) begin
                armed <= 1'b0;
                ticks <= '0;
            end else begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    // R6
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (ticks == '0));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_brk,
    input  logic             rbr_rd,
    input  logic             lsr_rd,
    input  logic             fcr_wr,
    input  logic [7:0]       fcr_wdata,
    input  logic             char_tick,
    output logic [7:0]       rbr_data,
    output logic [CNT_W-1:0] rx_fill,
    output logic             rx_trig,
    output logic             rx_tmo,
    output logic             ls_dr,
    output logic             ls_oe,
    output logic             ls_bi,
    output logic             tx_flush,
    output logic [7:0]       fcr_q
);
    import uart_rxq_pkg::*;

    fcr_t             fcr_r, fcr_in;
    line_stat_t       ls;
    logic             tmo_r, txf_r;
    logic             fifo_on, en_toggle, flush_rx, flush_tx;
    logic             rx_any, at_cap, push, pop, ovr, empties;
    logic [7:0]       rx_word, head;
    logic [CNT_W-1:0] fill, fill_nxt;
    logic             tmr_restart, tmr_stop, tmr_fire;

    assign fcr_in    = fcr_t'(fcr_wdata);
    assign fifo_on   = fcr_r.enable;
    assign en_toggle = fcr_wr & (fcr_in.enable ^ fcr_r.enable);
    assign flush_rx  = (fcr_wr & fcr_in.rx_clr) | en_toggle;
    assign flush_tx  = (fcr_wr & fcr_in.tx_clr) | en_toggle;

    assign rx_any   = rx_valid | rx_brk;
    assign rx_word  = rx_brk ? 8'h00 : rx_byte;
    assign at_cap   = fifo_on ? (fill == CNT_W'(DEPTH)) : (fill != '0);
    assign push     = rx_any & ~at_cap & ~flush_rx;
    assign ovr      = rx_any & at_cap & ~flush_rx;
    assign pop      = rbr_rd & (fill != '0) & ~flush_rx;
    assign fill_nxt = fill + CNT_W'(push) - CNT_W'(pop);
    assign empties  = pop & (fill_nxt == '0);

    assign tmr_stop    = flush_rx | ~fifo_on | (fill_nxt == '0);
    assign tmr_restart = fifo_on & (rx_any | pop);

    uart_rxq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (flush_rx),
        .push_i  (push),
        .data_i  (rx_word),
        .pop_i   (pop),
        .head_o  (head),
        .count_o (fill)
    );

    uart_rxq_timer #(.CHARS(TMO_CHARS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (tmr_restart),
        .stop_i    (tmr_stop),
        .tick_i    (char_tick),
        .fire_o    (tmr_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fcr_r <= '0;
            ls    <= '0;
            tmo_r <= 1'b0;
            txf_r <= 1'b0;
        end else begin
            txf_r <= flush_tx;
            if (fcr_wr)
                fcr_r <= fcr_t'(fcr_wdata & FCR_KEEP);

            if (flush_rx) begin
                ls.dr <= 1'b0;
                ls.bi <= 1'b0;
            end else begin
                if (push)
                    ls.dr <= 1'b1;
                else if (empties)
                    ls.dr <= 1'b0;

                if (push && rx_brk)
                    ls.bi <= 1'b1;
                else if (empties || lsr_rd)
                    ls.bi <= 1'b0;
            end

            if (ovr)
                ls.oe <= 1'b1;
            else if (lsr_rd)
                ls.oe <= 1'b0;

            if (flush_rx || rbr_rd)
                tmo_r <= 1'b0;
            else if (tmr_fire && (fill != '0))
                tmo_r <= 1'b1;
        end
    end

    assign rbr_data = (fill != '0) ? head : 8'h00;
    assign rx_fill  = fill;
    assign rx_trig  = fifo_on ? (fill >= CNT_W'(trig_level(fcr_r.trig))) : ls.dr;
    assign rx_tmo   = tmo_r;
    assign ls_dr    = ls.dr;
    assign ls_oe    = ls.oe;
    assign ls_bi    = ls.bi;
    assign tx_flush = txf_r;
    assign fcr_q    = fcr_r;

    // R5
    dr_fill_chk: assert property (@(posedge clk) disable iff (rst)
        ls.dr == (fill != '0));

    // R4
    bi_dr_chk: assert property (@(posedge clk) disable iff (rst)
        ls.bi |-> ls.dr);

    // R2
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_on && fill == CNT_W'(DEPTH) && rx_any && !rbr_rd && !fcr_wr)
        |=> (fill == CNT_W'(DEPTH) && ls.oe));

    // R6
    tmo_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_r) |-> (fill != '0));

    // R9
    flush_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && fcr_in.rx_clr) |=> (fill == '0 && !ls.dr && !tmo_r));

    // R10
    flush_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && fcr_in.tx_clr) |=> tx_flush);

    // R11
    single_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        (!fifo_on && !fcr_wr) |=> !tmo_r);

endmodule

// File: tb/uart_rxq_bench.sv
`timescale 1ns/1ps
module uart_rxq_bench;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_brk = 0, rbr_rd = 0, lsr_rd = 0, fcr_wr = 0, char_tick = 0;
    logic [7:0] rx_byte = 0, fcr_wdata = 0;
    logic [7:0] rbr_data, fcr_q;
    logic [CNT_W-1:0] rx_fill;
    logic rx_trig, rx_tmo, ls_dr, ls_oe, ls_bi, tx_flush;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    uart_rxq u_uart_rxq (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_brk(rx_brk),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .char_tick(char_tick), .rbr_data(rbr_data), .rx_fill(rx_fill), .rx_trig(rx_trig),
        .rx_tmo(rx_tmo), .ls_dr(ls_dr), .ls_oe(ls_oe), .ls_bi(ls_bi),
        .tx_flush(tx_flush), .fcr_q(fcr_q)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference
    logic [7:0] q[$];
    logic [7:0] m_fcr = 0;
    bit m_dr, m_oe, m_bi, m_tmo, m_txf, m_armed;
    int m_ticks;

    function automatic int level(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        int cnt, nxt, cap;
        bit fon, tog, frx, any, room, did_push, did_pop, ovr, fire, stop, rs;
        cycles++;
        if (rst) begin
            q.delete();
            m_fcr = 0; m_dr = 0; m_oe = 0; m_bi = 0; m_tmo = 0; m_txf = 0;
            m_armed = 0; m_ticks = 0;
        end else begin
            cnt = q.size();
            fon = m_fcr[0];
            cap = fon ? DEPTH : 1;
            tog = fcr_wr && (fcr_wdata[0] != m_fcr[0]);
            frx = (fcr_wr && fcr_wdata[1]) || tog;
            any = rx_valid || rx_brk;
            room = cnt < cap;
            did_push = any && room && !frx;
            ovr = any && !room && !frx;
            did_pop = rbr_rd && cnt > 0 && !frx;
            nxt = cnt + (did_push ? 1 : 0) - (did_pop ? 1 : 0);
            stop = frx || !fon || nxt == 0;
            rs = fon && (any || did_pop);
            fire = m_armed && char_tick && m_ticks == 3 && !rs && !stop;

            m_txf = (fcr_wr && fcr_wdata[2]) || tog;
            if (frx) begin
                q.delete(); m_dr = 0; m_bi = 0;
            end else begin
                if (did_pop) void'(q.pop_front());
                if (did_push) q.push_back(rx_brk ? 8'h00 : rx_byte);
                if (did_push) m_dr = 1; else if (did_pop && nxt == 0) m_dr = 0;
                if (did_push && rx_brk) m_bi = 1;
                else if ((did_pop && nxt == 0) || lsr_rd) m_bi = 0;
            end
            if (ovr) m_oe = 1; else if (lsr_rd) m_oe = 0;
            if (frx || rbr_rd) m_tmo = 0; else if (fire && cnt > 0) m_tmo = 1;
            if (stop) begin m_armed = 0; m_ticks = 0; end
            else if (rs) begin m_armed = 1; m_ticks = 0; end
            else if (m_armed && char_tick) begin
                if (m_ticks == 3) begin m_armed = 0; m_ticks = 0; end
                else m_ticks++;
            end
            if (fcr_wr) m_fcr = fcr_wdata & 8'hC9;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(rbr_data, (q.size() > 0) ? q[0] : 0, "R1 data");
            chk(rx_fill, q.size(), "R1 fill");
            chk(rx_trig, m_fcr[0] ? (q.size() >= level(m_fcr[7:6])) : m_dr, "R3 trig");
            chk(rx_tmo, m_tmo, "R6 timeout");
            chk(ls_dr, m_dr, "R5 dr");
            chk(ls_oe, m_oe, "R2 oe");
            chk(ls_bi, m_bi, "R4 bi");
            chk(tx_flush, m_txf, "R10 tx_flush");
            chk(fcr_q, m_fcr, "R8 fcr");
        end
    end

    always @(posedge clk) begin
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input bit rv, input logic [7:0] b, input bit brk, input bit rd,
                       input bit lr, input bit fw, input logic [7:0] fd, input bit tk);
        @(negedge clk);
        rx_valid = rv; rx_byte = b; rx_brk = brk; rbr_rd = rd; lsr_rd = lr;
        fcr_wr = fw; fcr_wdata = fd; char_tick = tk;
        @(posedge clk);
        #1;
        rx_valid = 0; rx_brk = 0; rbr_rd = 0; lsr_rd = 0; fcr_wr = 0; char_tick = 0;
    endtask

    task automatic put(input logic [7:0] b); cyc(1, b, 0, 0, 0, 0, 0, 0); endtask
    task automatic rd();  cyc(0, 0, 0, 1, 0, 0, 0, 0); endtask
    task automatic wfcr(input logic [7:0] v); cyc(0, 0, 0, 0, 0, 1, v, 0); endtask
    task automatic tick(); cyc(0, 0, 0, 0, 0, 0, 0, 1); endtask
    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R12 reset state
        chk(fcr_q, 0, "R12 fcr");
        chk(rx_fill, 0, "R12 fill");
        chk({ls_dr, ls_oe, ls_bi, rx_tmo, rx_trig, tx_flush}, 0, "R12 flags");

        // single-byte mode
        put(8'hA5);
        chk(rx_trig, 1, "R11 trig equals dr");
        put(8'h3C);
        chk(ls_oe, 1, "R2 single overrun");
        chk(rbr_data, 8'hA5, "R2 old byte kept");
        for (int i = 0; i < 6; i++) tick();
        chk(rx_tmo, 0, "R11 no timeout");
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk(ls_oe, 0, "R2 lsr read clears oe");
        rd();
        chk(ls_dr, 0, "R5 read empties");
        chk(rbr_data, 0, "R1 empty reads zero");

        // enable queue mode: toggle flushes both
        put(8'h11);
        wfcr(8'h01);
        chk(rx_fill, 0, "R9 toggle flush");
        chk(tx_flush, 1, "R10 pulse");
        idle();
        chk(tx_flush, 0, "R10 one cycle");
        wfcr(8'hFF);
        chk(fcr_q, 8'hC9, "R8 mask");

        // fill past capacity
        for (int i = 0; i < 20; i++) put(8'(i * 7 + 1));
        chk(rx_fill, DEPTH, "R2 fill capped");
        chk(ls_oe, 1, "R2 queue overrun");
        chk(rx_trig, 1, "R3 level 14");
        for (int i = 0; i < DEPTH; i++) begin
            chk(rbr_data, 8'(i * 7 + 1), "R1 order");
            rd();
        end
        chk(ls_dr, 0, "R5 drained");

        // break
        cyc(1, 8'h77, 1, 0, 0, 0, 0, 0);
        chk(rbr_data, 0, "R4 null byte");
        chk({ls_bi, ls_dr}, 3, "R4 flags");
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk(ls_bi, 0, "R5 lsr clears bi");
        chk(ls_dr, 1, "R5 dr stays");

        // timeout
        wfcr(8'h03);
        chk(rx_fill, 0, "R9 rx flush");
        put(8'h21); put(8'h22);
        for (int i = 0; i < 3; i++) tick();
        chk(rx_tmo, 0, "R6 three ticks");
        tick();
        chk(rx_tmo, 1, "R6 fourth tick");
        rd();
        chk(rx_tmo, 0, "R7 read clears");
        for (int i = 0; i < 4; i++) tick();
        chk(rx_tmo, 1, "R6 restart after read");
        rd();
        chk(rx_tmo, 0, "R7 clear on emptying read");
        rd();
        chk(rx_tmo, 0, "R7 empty read");

        // thresholds
        wfcr(8'h43);
        for (int i = 0; i < 3; i++) put(8'(i));
        chk(rx_trig, 0, "R3 below 4");
        put(8'h09);
        chk(rx_trig, 1, "R3 at 4");
        wfcr(8'h83);
        for (int i = 0; i < 7; i++) put(8'(i));
        chk(rx_trig, 0, "R3 below 8");
        put(8'h09);
        chk(rx_trig, 1, "R3 at 8");
        wfcr(8'hC3);
        for (int i = 0; i < 13; i++) put(8'(i));
        chk(rx_trig, 0, "R3 below 14");
        put(8'h09);
        chk(rx_trig, 1, "R3 at 14");
        wfcr(8'h05);
        chk(tx_flush, 1, "R10 tx bit");
        chk(rx_fill, 14, "R9 no rx flush without bit");

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] r;
            logic [7:0] f;
            r = 8'($urandom);
            f = 8'($urandom);
            if ((i % 500) != 0) f[0] = 1'b1;
            cyc(r[0] & r[1], 8'($urandom), (r[7:2] == 0), r[2] & r[3],
                (r[6:4] == 0), ($urandom_range(0, 40) == 0), f, r[5]);
        end

        idle();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule